// File: doc/BRIEF.md
# Core Power-State and Clock-Source Controller

This controller decides which clock feeds the processor core, whether that clock runs at all, and whether the core is powered. It has three resting states. In run the core is clocked from the fast PLL clock. In idle the core clock is stopped, but state, power and the PLL are all kept, so a wake event resumes execution at once. In sleep the core and the PLL are switched off and only the pin ring stays powered. A wake event from sleep runs a reset-like sequence: power comes up, the PLL is re-enabled and must report lock, and a restore request is held until the core has reloaded its state from memory.

While a blocking cache miss is outstanding, the core can do nothing useful, so the controller moves it to the slower system clock and moves it back when the miss ends. Every change of clock source passes through one cycle in which the core clock is disabled. Each functional unit gets its own clock-enable condition, so an inactive unit is held by its clock and not by data enables. All pins are level control signals with no handshake. The controller itself runs on an always-on reference clock, and the glitch-free clock cells it steers lie outside this block.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the block is in run. It drives clock select 0 (fast PLL clock), core clock enable 1, power enable 1, PLL enable 1 and restore request 0, and each unit enable follows its activity input.
- R2: In run, a cache-miss-pending input steps the core through one cycle with core clock enable 0 while clock select is still 0. In the next cycle clock select is 1 (slow system clock) and core clock enable is 1.
- R3: In the slow state, when miss-pending goes low, the core passes through one cycle with core clock enable 0 and clock select still 1. It then returns to run with clock select 0.
- R4: While power is enabled, clock select only changes in a cycle that follows one in which core clock enable was 0.
- R5: An idle request in run stops the core clock, keeps power and PLL enabled, and turns all unit enables off. A wake event in idle re-enables the core clock on the next cycle.
- R6: In sleep, power enable, PLL enable, core clock enable, restore request and all unit enables are 0.
- R7: A wake event in sleep raises power enable alone for one cycle. PLL enable then rises. Once the lock input has been high for LOCK_CYCLES consecutive cycles, the restore request and the core clock enable rise together. Both stay high until restore-done, after which the block is in run.
- R8: A drop of the lock input during the wait restarts the count of consecutive lock cycles.
- R9: A sleep request made during a miss is held until the miss ends, and sleep is then entered directly. Idle requests during a miss have no effect.
- R10: A unit enable is 1 only when that unit's activity input is 1 and the block is in run or in the slow state.
- R11: In run, the three requests are honoured in a fixed order: miss-pending first, then sleep, then idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Always-on reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idle_req_i | input | 1 | Request to stop the core clock |
| sleep_req_i | input | 1 | Request to power the core down |
| wake_i | input | 1 | Wake event |
| miss_pend_i | input | 1 | Blocking cache miss outstanding |
| pll_lock_i | input | 1 | PLL lock indication |
| restore_done_i | input | 1 | Core has reloaded its state |
| unit_act_i | input | NUM_UNITS | Per-unit activity requests |
| clk_sel_o | output | 1 | 0 = fast PLL clock, 1 = slow system clock |
| core_clk_en_o | output | 1 | Core clock enable |
| unit_clk_en_o | output | NUM_UNITS | Per-unit gated-clock enables |
| core_pwr_en_o | output | 1 | Core power enable |
| pll_en_o | output | 1 | PLL enable |
| restore_req_o | output | 1 | Reset-style state restore request |

## Verification
Some rules hold in every cycle, and the assertions check these: the dead cycle before any change of clock source, PLL enable never without power, power rising ahead of PLL enable, the restore request only following qualified lock, and unit enables never running ahead of the core clock or of their activity input. Other behaviour depends on a sequence of events, and only the bench scenarios show it. This covers the exact cycles of the miss round trip, a sleep request deferred across a miss, idle requests ignored during a miss, the one-cycle idle wake, the lock count restarting after a glitch, and the order in which competing requests are taken in run.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_GAP    = 3'd1,
    ST_SLOW   = 3'd2,
    ST_IDLE   = 3'd3,
    ST_SLEEP  = 3'd4,
    ST_WK_PWR = 3'd5,
    ST_WK_PLL = 3'd6,
    ST_WK_RST = 3'd7
  } pcc_state_e;

  typedef struct packed {
    logic clk_sel;
    logic core_en;
    logic pwr_en;
    logic pll_en;
    logic restore;
    logic units_on;
  } pcc_ctl_t;

endpackage

// File: rtl/pcc_lock_qual.sv
module pcc_lock_qual #(
  parameter int LOCK_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pll_en_i,
  input  logic pll_lock_i,
  output logic locked_o
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt_q;

  // Consecutive-cycle lock counter; any drop restarts it (R8)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!pll_en_i || !pll_lock_i) cnt_q <= '0;
    else if (cnt_q != FULL)          cnt_q <= cnt_q + 1'b1;
  end

  assign locked_o = (cnt_q == FULL);
endmodule

// File: rtl/pcc_fsm.sv
module pcc_fsm
  import pcc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     idle_req_i,
  input  logic     sleep_req_i,
  input  logic     wake_i,
  input  logic     miss_pend_i,
  input  logic     locked_i,
  input  logic     restore_done_i,
  output pcc_ctl_t ctl_o
);
  pcc_state_e st_q, st_d;
  logic to_slow_q, to_slow_d;
  logic slp_pend_q, slp_pend_d;
  logic slp_any;

  assign slp_any = sleep_req_i | slp_pend_q;

  always_comb begin
    st_d      = st_q;
    to_slow_d = to_slow_q;
    unique case (st_q)
      ST_RUN: begin
        // R11: miss first, then sleep, then idle
        if (miss_pend_i) begin
          st_d      = ST_GAP;
          to_slow_d = 1'b1;
        end else if (slp_any) begin
          st_d = ST_SLEEP;
        end else if (idle_req_i) begin
          st_d = ST_IDLE;
        end
      end
      ST_GAP:   st_d = to_slow_q ? ST_SLOW : ST_RUN;
      ST_SLOW: begin
        if (!miss_pend_i) begin
          if (slp_any) begin
            st_d = ST_SLEEP;
          end else begin
            st_d      = ST_GAP;
            to_slow_d = 1'b0;
          end
        end
      end
      ST_IDLE: begin
        if (wake_i)           st_d = ST_RUN;
        else if (sleep_req_i) st_d = ST_SLEEP;
      end
      ST_SLEEP:  if (wake_i) st_d = ST_WK_PWR;
      ST_WK_PWR: st_d = ST_WK_PLL;
      ST_WK_PLL: if (locked_i) st_d = ST_WK_RST;
      ST_WK_RST: if (restore_done_i) st_d = ST_RUN;
      default:   st_d = ST_RUN;
    endcase
  end

  // R9: sleep requests seen during a miss are held
  always_comb begin
    slp_pend_d = slp_pend_q;
    if (st_q == ST_SLEEP)
      slp_pend_d = 1'b0;
    else if ((st_q == ST_GAP || st_q == ST_SLOW) && sleep_req_i)
      slp_pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_RUN;
      to_slow_q  <= 1'b0;
      slp_pend_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      to_slow_q  <= to_slow_d;
      slp_pend_q <= slp_pend_d;
    end
  end

  always_comb begin
    ctl_o = '{clk_sel: 1'b0, core_en: 1'b0, pwr_en: 1'b1,
              pll_en: 1'b1, restore: 1'b0, units_on: 1'b0};
    unique case (st_q)
      ST_RUN:    begin ctl_o.core_en = 1'b1; ctl_o.units_on = 1'b1; end
      ST_GAP:    ctl_o.clk_sel = ~to_slow_q;
      ST_SLOW:   begin ctl_o.clk_sel = 1'b1; ctl_o.core_en = 1'b1; ctl_o.units_on = 1'b1; end
      ST_IDLE:   ;
      ST_SLEEP:  begin ctl_o.pwr_en = 1'b0; ctl_o.pll_en = 1'b0; end
      ST_WK_PWR: ctl_o.pll_en = 1'b0;
      ST_WK_PLL: ;
      ST_WK_RST: begin ctl_o.core_en = 1'b1; ctl_o.restore = 1'b1; end
      default:   ;
    endcase
  end
endmodule

// File: rtl/pcc_unit_gate.sv
module pcc_unit_gate #(
  parameter int NUM_UNITS = 4
) (
  input  logic                 units_on_i,
  input  logic [NUM_UNITS-1:0] act_i,
  output logic [NUM_UNITS-1:0] en_o
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign en_o[u] = units_on_i & act_i[u];
  end
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pcc_pkg::*;
#(
  parameter int NUM_UNITS   = 4,
  parameter int LOCK_CYCLES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 idle_req_i,
  input  logic                 sleep_req_i,
  input  logic                 wake_i,
  input  logic                 miss_pend_i,
  input  logic                 pll_lock_i,
  input  logic                 restore_done_i,
  input  logic [NUM_UNITS-1:0] unit_act_i,
  output logic                 clk_sel_o,
  output logic                 core_clk_en_o,
  output logic [NUM_UNITS-1:0] unit_clk_en_o,
  output logic                 core_pwr_en_o,
  output logic                 pll_en_o,
  output logic                 restore_req_o
);
  pcc_ctl_t ctl;
  logic     locked;

  pcc_lock_qual #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i, .rst_ni, .pll_en_i(ctl.pll_en), .pll_lock_i, .locked_o(locked)
  );

  pcc_fsm u_fsm (
    .clk_i, .rst_ni, .idle_req_i, .sleep_req_i, .wake_i, .miss_pend_i,
    .locked_i(locked), .restore_done_i, .ctl_o(ctl)
  );

  pcc_unit_gate #(.NUM_UNITS(NUM_UNITS)) u_gate (
    .units_on_i(ctl.units_on), .act_i(unit_act_i), .en_o(unit_clk_en_o)
  );

  assign clk_sel_o     = ctl.clk_sel;
  assign core_clk_en_o = ctl.core_en;
  assign core_pwr_en_o = ctl.pwr_en;
  assign pll_en_o      = ctl.pll_en;
  assign restore_req_o = ctl.restore;
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int NUM_UNITS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 pll_lock_i,
  input logic [NUM_UNITS-1:0] unit_act_i,
  input logic                 clk_sel_o,
  input logic                 core_clk_en_o,
  input logic [NUM_UNITS-1:0] unit_clk_en_o,
  input logic                 core_pwr_en_o,
  input logic                 pll_en_o,
  input logic                 restore_req_o
);
  assert_dead_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_pwr_en_o && !$stable(clk_sel_o)) |-> !$past(core_clk_en_o));

  assert_sleep_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_pwr_en_o |-> (!core_clk_en_o && !pll_en_o && !restore_req_o && unit_clk_en_o == '0));

  assert_pwr_before_pll_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_pwr_en_o) |-> !pll_en_o);

  assert_restore_after_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(restore_req_o) |-> ($past(pll_en_o) && $past(pll_lock_i)));

  assert_pll_needs_pwr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_en_o |-> core_pwr_en_o);

  assert_unit_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_clk_en_o != '0) |-> (core_clk_en_o && !restore_req_o && (unit_clk_en_o & ~unit_act_i) == '0));
endmodule

bind pwr_clk_ctrl pcc_checker #(.NUM_UNITS(NUM_UNITS)) u_chk (
  .clk_i, .rst_ni, .pll_lock_i, .unit_act_i, .clk_sel_o, .core_clk_en_o,
  .unit_clk_en_o, .core_pwr_en_o, .pll_en_o, .restore_req_o
);

// File: tb/tb_pwr_clk_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_clk_ctrl;
  localparam int NU = 4;
  localparam int LC = 4;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle, slp, wake, miss, lock, rdone;
  logic [NU-1:0] act;
  logic sel, core, pwr, pll, rst_req;
  logic [NU-1:0] uen;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_clk_ctrl #(.NUM_UNITS(NU), .LOCK_CYCLES(LC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .idle_req_i(idle), .sleep_req_i(slp),
    .wake_i(wake), .miss_pend_i(miss), .pll_lock_i(lock), .restore_done_i(rdone),
    .unit_act_i(act), .clk_sel_o(sel), .core_clk_en_o(core), .unit_clk_en_o(uen),
    .core_pwr_en_o(pwr), .pll_en_o(pll), .restore_req_o(rst_req)
  );

  // inputs {idle,sleep,wake,miss,lock,rdone,act[3:0]}, expected {sel,core,pwr,pll,restore,units[3:0]}
  localparam logic [18:0] VEC [NV] = '{
    {10'b000000_1010, 9'b01110_1010},  // R1 R10 run, units follow activity
    {10'b000100_1111, 9'b00110_0000},  // R2 dead cycle, old source
    {10'b000100_1111, 9'b11110_1111},  // R2 slow clock
    {10'b100100_0011, 9'b11110_0011},  // R9 idle ignored during miss
    {10'b010100_0011, 9'b11110_0011},  // R9 sleep held
    {10'b000000_0011, 9'b00000_0000},  // R9 R6 sleep after miss ends
    {10'b000000_0011, 9'b00000_0000},  // R6 stays asleep
    {10'b001000_0000, 9'b00100_0000},  // R7 power first
    {10'b000000_0000, 9'b00110_0000},  // R7 pll next
    {10'b000000_0000, 9'b00110_0000}   // R7 waiting for lock
  };

  function automatic logic [8:0] outs();
    return {sel, core, pwr, pll, rst_req, uen};
  endfunction

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic drive(input logic [9:0] v);
    {idle, slp, wake, miss, lock, rdone, act} = v;
  endtask

  task automatic step(input logic [9:0] v);
    drive(v);
    @(negedge clk);
  endtask

  initial begin
    drive(10'b000000_0101);
    repeat (3) @(negedge clk);
    check("R1 reset", outs(), 9'b01110_0101);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", outs(), 9'b01110_0101);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][18:9]);
      check($sformatf("vector %0d (R1-table)", i), outs(), VEC[i][8:0]);
    end

    // R8: lock glitch restarts qualification
    step(10'b000010_0000);
    step(10'b000010_0000);
    step(10'b000000_0000);
    check("R8 no restore after glitch", outs(), 9'b00110_0000);
    drive(10'b000010_0000);
    repeat (LC) @(negedge clk);
    check("R8 still waiting for full count", outs(), 9'b00110_0000);
    @(negedge clk);
    check("R7 restore request", outs(), 9'b01111_0000);
    step(10'b000011_0110);
    check("R7 run after restore done", outs(), 9'b01110_0110);

    // R5 idle and quick wake
    step(10'b100010_0110);
    check("R5 idle", outs(), 9'b00110_0000);
    step(10'b000010_0110);
    step(10'b000010_0110);
    check("R5 idle held", outs(), 9'b00110_0000);
    step(10'b001010_0110);
    check("R5 wake next cycle", outs(), 9'b01110_0110);

    // R11 miss wins over sleep and idle; R3 return path
    step(10'b110110_1001);
    check("R11 miss first", outs(), 9'b00110_0000);
    step(10'b000110_1001);
    check("R2 slow", outs(), 9'b11110_1001);
    step(10'b000010_1001);
    check("R3 dead cycle on return", outs(), 9'b10110_0000);
    step(10'b000010_1001);
    check("R3 fast clock again", outs(), 9'b01110_1001);

    // R11 sleep wins over idle
    step(10'b110010_1001);
    check("R11 sleep before idle", outs(), 9'b00000_0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all R) actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule